// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the serial-interface front end that a serial flash model uses for writes to its status register. The block runs on a fast system clock. It oversamples the serial clock, the active-low chip select and the serial data input through synchronizers. On each rising serial-clock edge inside a frame it shifts in one bit, most significant bit first. The first byte of a frame is the command byte and the second byte is the data byte.

A write-enable latch is armed by a frame that carries either of two enable commands, and it is disarmed by the disable command. A status write is carried by a separate frame that holds the write command and one data byte. That write is committed only when chip select rises directly after the data byte. Even then it goes through a guard that looks at the write-protect pin and the lock bit. While the pin is low, the lock bit can be set but never cleared. Once the lock bit is set with the pin low, no write gets through. The serial output is never driven.

Top module: `spi_sr_guard`

## Requirements
- R1: After reset the status output is 8'h00, the enable latch is clear and the serial output enable is low.
- R2: Status bit positions: bit 2, bit 3 and bit 4 are the three block-protect bits and bit 7 is the lock bit. Bits 0, 1, 5 and 6 always read zero.
- R3: A frame of command 8'h06 arms the enable latch. A following frame of command 8'h01 plus one data byte then loads the status bits from that byte.
- R4: Command 8'h50 arms the enable latch in the same way as 8'h06.
- R5: A write frame whose length is not exactly 16 bits leaves the status unchanged. A frame with fewer than 8 bits has no effect at all.
- R6: A write frame of at least 8 bits clears the enable latch, whether the write was committed or refused. A second write without a new enable therefore changes nothing.
- R7: A frame of command 8'h04 clears the enable latch.
- R8: With the protect pin high at the end of the frame, a write may set or clear every bit, including the lock bit.
- R9: With the protect pin low and the lock bit 0, a single write may set the lock bit and change the protect bits together.
- R10: With the protect pin low and the lock bit 1, a write is ignored entirely and the lock bit stays 1.
- R11: A frame with any other command byte leaves both the status and the enable latch unchanged.
- R12: The serial output enable stays low through all frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock; data is sampled on its rising edge |
| cs_n | input | 1 | Active-low chip select that frames a command |
| si | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Active-low write-protect pin |
| so_d | output | 1 | Serial output data (unused, held low) |
| so_oe | output | 1 | Serial output enable, always low (high impedance) |
| status | output | 8 | Current status register value |

## Verification
Every pin passes through two synchronizer flops. One more stage then detects the edge, so a status change or latch change appears on the third system-clock edge after chip select rises. The bench holds each serial level for four system clocks. After each frame it waits twelve clocks before it compares the status with its model, and it samples on the falling clock edge. The protect pin is set at least twenty clocks before a frame ends, so the value the guard sees at chip-select rise is the one the bench model uses.

// File: rtl/spi_sr_guard_pkg.sv
package spi_sr_guard_pkg;
  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_EWSR = 8'h50;
  localparam logic [7:0] CMD_WRDI = 8'h04;
  localparam logic [7:0] CMD_WRSR = 8'h01;

  localparam int BP_LSB  = 2;
  localparam int BP_W    = 3;
  localparam int LOCK_IX = 7;

  localparam int DATA_W = 8;

  typedef struct packed {
    logic            lock;
    logic [BP_W-1:0] bp;
  } sr_fields_t;

  function automatic logic [DATA_W-1:0] pack_status(input sr_fields_t f);
    logic [DATA_W-1:0] v;
    v = '0;
    v[LOCK_IX] = f.lock;
    v[BP_LSB +: BP_W] = f.bp;
    return v;
  endfunction
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_sr_rx.sv
module spi_sr_rx
  import spi_sr_guard_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              si_s,
  output logic [DATA_W-1:0] cmd_byte,
  output logic [DATA_W-1:0] data_byte,
  output logic              frame_end,
  output logic [CNT_W-1:0]  frame_bits
);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(2 * DATA_W - 1);

  logic              sck_q, cs_q;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] cmd_q, cmd_d, dat_q, dat_d;
  logic              sck_rise, cs_rise;

  assign sck_rise = sck_s & ~sck_q & ~cs_n_s;
  assign cs_rise  = cs_n_s & ~cs_q;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    cmd_d = cmd_q;
    dat_d = dat_q;
    if (cs_n_s) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      sh_d = {sh_q[DATA_W-2:0], si_s};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (cnt_q == CMD_LAST)  cmd_d = sh_d;
      if (cnt_q == DATA_LAST) dat_d = sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      sh_q  <= '0;
      cnt_q <= '0;
      cmd_q <= '0;
      dat_q <= '0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      cmd_q <= cmd_d;
      dat_q <= dat_d;
    end
  end

  assign cmd_byte   = cmd_q;
  assign data_byte  = dat_q;
  assign frame_end  = cs_rise;
  assign frame_bits = cnt_q;

  // R5: the bit count is back at zero once chip select has been high for two samples
  assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && cs_q) |-> (cnt_q == '0));

  // R5: bits are only counted inside a frame
  assert_no_count_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt_q == '0));
endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
  import spi_sr_guard_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [CNT_W-1:0]  frame_bits,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              wp_n_s,
  output logic [DATA_W-1:0] status,
  output logic              wel
);
  localparam logic [CNT_W-1:0] ONE_BYTE  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] TWO_BYTES = CNT_W'(2 * DATA_W);

  sr_fields_t sr_q, sr_d;
  logic       wel_q, wel_d;
  logic       cmd_done, write_ok;

  assign cmd_done = frame_end && (frame_bits >= ONE_BYTE);
  assign write_ok = wel_q && (frame_bits == TWO_BYTES) && (wp_n_s || !sr_q.lock);

  always_comb begin
    sr_d  = sr_q;
    wel_d = wel_q;
    if (cmd_done) begin
      unique case (cmd_byte)
        CMD_WREN, CMD_EWSR: wel_d = 1'b1;
        CMD_WRDI:           wel_d = 1'b0;
        CMD_WRSR: begin
          wel_d = 1'b0;
          if (write_ok) begin
            sr_d.lock = data_byte[LOCK_IX];
            sr_d.bp   = data_byte[BP_LSB +: BP_W];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      wel_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      wel_q <= wel_d;
    end
  end

  assign status = pack_status(sr_q);
  assign wel    = wel_q;

  // R10: with the pin low a set lock bit holds and freezes the protect bits
  assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n_s && sr_q.lock) |=> (sr_q.lock && $stable(sr_q.bp)));

  // R5: the status moves only at the end of a frame
  assert_stat_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(sr_q));

  // R6: a completed write frame leaves the latch clear
  assert_wel_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cmd_byte == CMD_WRSR) |=> !wel_q);

  // R3: without an armed latch the status cannot change
  assert_no_unarmed_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_q |=> $stable(sr_q));
endmodule

// File: rtl/spi_sr_guard.sv
module spi_sr_guard
  import spi_sr_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              wp_n,
  output logic              so_d,
  output logic              so_oe,
  output logic [DATA_W-1:0] status
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  logic [3:0] pins_s;
  logic       wel_unused;

  spi_sr_sync #(
    .WIDTH   (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   ({wp_n, sck, cs_n, si}),
    .dout  (pins_s)
  );

  logic [DATA_W-1:0] cmd_byte, data_byte;
  logic              frame_end;
  logic [CNT_W-1:0]  frame_bits;

  spi_sr_rx #(.CNT_W(CNT_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .sck_s      (pins_s[2]),
    .cs_n_s     (pins_s[1]),
    .si_s       (pins_s[0]),
    .cmd_byte   (cmd_byte),
    .data_byte  (data_byte),
    .frame_end  (frame_end),
    .frame_bits (frame_bits)
  );

  spi_sr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .frame_end  (frame_end),
    .frame_bits (frame_bits),
    .cmd_byte   (cmd_byte),
    .data_byte  (data_byte),
    .wp_n_s     (pins_s[3]),
    .status     (status),
    .wel        (wel_unused)
  );

  assign so_d  = 1'b0;
  assign so_oe = 1'b0;

  // R2: the bits that have no field always read zero
  assert_fixed_zero_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (status[1:0] == 2'b00) && (status[6:5] == 2'b00));
endmodule

// File: tb/spi_sr_guard_test.sv
module spi_sr_guard_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic       so_d, so_oe;
  logic [7:0] status;

  int checks = 0, errors = 0;
  logic [7:0] m_stat = 8'h00;
  logic       m_wel  = 1'b0;
  int         oe_seen = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  spi_sr_guard uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so_d(so_d), .so_oe(so_oe), .status(status)
  );

  always @(negedge clk) if (so_oe !== 1'b0) oe_seen++;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic void model(input logic [7:0] op, input logic [7:0] dat, input int n,
                                input logic wp);
    if (n < 8) return;
    case (op)
      8'h06, 8'h50: m_wel = 1'b1;
      8'h04:        m_wel = 1'b0;
      8'h01: begin
        if (m_wel && n == 16 && (wp || !m_stat[7])) m_stat = dat & 8'h9C;
        m_wel = 1'b0;
      end
      default: ;
    endcase
  endfunction

  task automatic frame(input logic [7:0] op, input logic [7:0] dat, input int n,
                       input string req);
    logic [23:0] bits;
    bits = {op, dat, 8'h5A};
    cs_n = 1'b0;
    waitc(4);
    for (int i = 0; i < n; i++) begin
      si = bits[23-i];
      waitc(4);
      sck = 1'b1;
      waitc(4);
      sck = 1'b0;
    end
    waitc(4);
    cs_n = 1'b1;
    model(op, dat, n, wp_n);
    waitc(12);
    chk(req, status, m_stat);
  endtask

  task automatic set_wp(input logic v);
    wp_n = v;
    waitc(20);
  endtask

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(6);
    // R1: reset state
    chk("R1 status", status, 8'h00);
    chk("R1 so_oe", {7'd0, so_oe}, 8'h00);

    // R3 / R2: enable then write, unused bits masked
    frame(8'h06, 8'h00, 8, "R3 wren");
    frame(8'h01, 8'hFF, 16, "R2 R3 write all ones");
    chk("R2 mask", status, 8'h9C);
    // R8: pin high, lock can be cleared
    frame(8'h50, 8'h00, 8, "R4 ewsr");
    frame(8'h01, 8'h0C, 16, "R8 clear lock");
    chk("R8 value", status, 8'h0C);
    // R6: second write without enable ignored
    frame(8'h01, 8'h10, 16, "R6 no rearm");
    chk("R6 value", status, 8'h0C);
    // R5: wrong lengths
    frame(8'h06, 8'h00, 8, "R3 wren");
    frame(8'h01, 8'h90, 15, "R5 short write");
    frame(8'h06, 8'h00, 8, "R3 wren");
    frame(8'h01, 8'h90, 17, "R5 long write");
    frame(8'h06, 8'h00, 7, "R5 short enable");
    frame(8'h01, 8'h90, 16, "R5 enable not taken");
    chk("R5 value", status, 8'h0C);
    // R7: disable clears latch
    frame(8'h06, 8'h00, 8, "R3 wren");
    frame(8'h04, 8'h00, 8, "R7 wrdi");
    frame(8'h01, 8'h80, 16, "R7 write after wrdi");
    chk("R7 value", status, 8'h0C);
    // R11: unknown opcode leaves latch armed
    frame(8'h06, 8'h00, 8, "R3 wren");
    frame(8'hAB, 8'h00, 16, "R11 unknown");
    frame(8'h01, 8'h14, 16, "R11 write still armed");
    chk("R11 value", status, 8'h14);
    // R9: pin low, lock 0 -> set lock and bp together
    set_wp(1'b0);
    frame(8'h06, 8'h00, 8, "R3 wren");
    frame(8'h01, 8'h88, 16, "R9 set lock");
    chk("R9 value", status, 8'h88);
    // R10: pin low, lock 1 -> ignored
    frame(8'h50, 8'h00, 8, "R4 ewsr");
    frame(8'h01, 8'h00, 16, "R10 blocked");
    chk("R10 value", status, 8'h88);
    set_wp(1'b1);
    frame(8'h06, 8'h00, 8, "R3 wren");
    frame(8'h01, 8'h04, 16, "R8 unlock with pin high");
    chk("R8 unlock", status, 8'h04);

    // random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 80; k++) begin
      logic [7:0] op, dat;
      int n, sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: op = 8'h06;
        3:       op = 8'h50;
        4:       op = 8'h04;
        5:       op = 8'($urandom);
        default: op = 8'h01;
      endcase
      dat = 8'($urandom);
      sel = $urandom_range(0, 9);
      if (op == 8'h01) n = (sel < 7) ? 16 : ((sel == 7) ? 15 : 17);
      else             n = (sel < 8) ? 8 : 7;
      if ($urandom_range(0, 3) == 0) set_wp(~wp_n);
      frame(op, dat, n, "R3 R9 R10 random");
    end

    // R12: output never enabled
    chk("R12 so_oe", 8'(oe_seen), 8'h00);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule